// File: doc/BRIEF.md
# Load/Store Effective-Address Sequencer

This block runs the memory side of a small 16-bit processor's data-movement instructions. It receives an instruction word together with the incremented program counter. It also receives the value of the register that the base field names and the value of the register that bits [11:9] name. From these it forms one effective address in one of three ways:

- **PC-relative:** the incremented PC plus a 9-bit offset.
- **Register base:** the base register plus a 6-bit offset.
- **Indirect:** a pointer fetched from a PC-relative location.

It then drives a single synchronous memory port, using a ready handshake that may stall any transfer.

Loads and the address-only form hand a result back: the destination index, the value, and a write enable. They do this in a one-cycle completion pulse, so that the register file outside can store the value and derive the condition codes from it. Stores return nothing. Fetch, the register file and the condition-code flags all sit outside the block. The block takes one instruction at a time and shows that it is occupied on `busy_o`.

Top module: `ldst_seq`

## Requirements
- R1: The block accepts `start_i` only while `busy_o` is low, and only when `instr_i[15:12]` is one of the following. Any other opcode is ignored: `busy_o` stays low and neither strobe nor `done_o` rises.

  | Opcode | Operation |
  |---|---|
  | 0010 | PC-relative load |
  | 0011 | PC-relative store |
  | 0110 | base load |
  | 0111 | base store |
  | 1010 | indirect load |
  | 1011 | indirect store |
  | 1110 | address-only |
- R2: For the PC-relative load and store, the address is `pc_next_i + sext(instr_i[8:0])` modulo 2^16. The same sum is the value that the address-only form returns, and it is the pointer location for both indirect forms. Offsets cover -256 to +255.
- R3: For the base load and store, the address is `base_val_i + sext(instr_i[5:0])` modulo 2^16, with offsets from -32 to +31.
- R4: An indirect operation first reads the PC-relative location. The word returned there becomes the address of a second transfer, which is a read for the indirect load and a write for the indirect store.
- R5: Each operation completes a fixed number of accepted transfers (strobe high with `mem_ready_i` high):

  | Operation | Accepted transfers |
  |---|---|
  | PC-relative load or store | 1 |
  | Base load or store | 1 |
  | Indirect load or store | 2 |
  | Address-only | 0 |
- R6: A store writes the `src_val_i` value captured at acceptance onto `mem_wdata_o`. Only the final transfer of a store raises `mem_wr_o`.
- R7: `mem_rd_o` and `mem_wr_o` are never high together. While a strobe is high and `mem_ready_i` is low, the strobes, `mem_addr_o` and `mem_wdata_o` hold their values.
- R8: `done_o` is a one-cycle pulse. With `mem_ready_i` held high, it is high in the following cycle after the clock edge that accepts `start_i`:

  | Operation | Cycle in which `done_o` is high |
  |---|---|
  | Address-only | 2nd |
  | Single-access | 3rd |
  | Indirect | 4th |
- R9: In the `done_o` cycle, `wr_en_o` is high for the three loads and for the address-only form, and low for stores. In that cycle `wr_idx_o` equals `instr_i[11:9]`. `wr_data_o` is the word read by the last transfer, or the computed address for the address-only form. `wr_en_o` is never high outside `done_o`.
- R10: `busy_o` is high from the cycle after acceptance through the `done_o` cycle, and is low in the cycle after it. A `start_i` seen while busy is ignored.
- R11: After reset, `busy_o`, `done_o`, `wr_en_o`, `mem_rd_o` and `mem_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation with the inputs below |
| instr_i | input | 16 | Instruction word |
| pc_next_i | input | WORD_W | Incremented program counter |
| base_val_i | input | WORD_W | Value of the register named by bits [8:6] |
| src_val_i | input | WORD_W | Value of the register named by bits [11:9] |
| busy_o | output | 1 | Operation in progress |
| mem_addr_o | output | WORD_W | Memory address |
| mem_wdata_o | output | WORD_W | Memory write data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_ready_i | input | 1 | Transfer accepted this cycle |
| mem_rdata_i | input | WORD_W | Read data, valid when ready |
| done_o | output | 1 | Completion pulse |
| wr_en_o | output | 1 | Register write request |
| wr_idx_o | output | 3 | Destination register index |
| wr_data_o | output | WORD_W | Value to write |

## Verification
The checks take for granted that `mem_rdata_i` carries the addressed word in any cycle where a read strobe meets `mem_ready_i`. They also take for granted that the instruction and register inputs matter only in the accepting cycle. Ready may stay low for any number of cycles.

The bench runs its memory in two ways: first with ready held high, so that latency can be checked, and then with ready asserted one cycle in three, so that every state stalls. It raises `start_i` only while the block is idle, apart from one deliberate hold into the busy period.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_IDX_W = 3;

  typedef enum logic [3:0] {
    OP_LD  = 4'b0010,
    OP_ST  = 4'b0011,
    OP_LDR = 4'b0110,
    OP_STR = 4'b0111,
    OP_LDI = 4'b1010,
    OP_STI = 4'b1011,
    OP_LEA = 4'b1110
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RD1,
    ST_ACCESS,
    ST_DONE
  } state_e;

  function automatic logic op_valid(input logic [3:0] op);
    case (op)
      OP_LD, OP_ST, OP_LDR, OP_STR, OP_LDI, OP_STI, OP_LEA: op_valid = 1'b1;
      default: op_valid = 1'b0;
    endcase
  endfunction

  function automatic logic op_store(input logic [3:0] op);
    op_store = (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
  endfunction

  function automatic logic op_indirect(input logic [3:0] op);
    op_indirect = (op == OP_LDI) || (op == OP_STI);
  endfunction

  function automatic logic op_base(input logic [3:0] op);
    op_base = (op == OP_LDR) || (op == OP_STR);
  endfunction
endpackage

// File: rtl/ldst_ea.sv
module ldst_ea
  import ldst_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [WORD_W-1:0]  pc_next_i,
  input  logic [WORD_W-1:0]  base_val_i,
  output logic [WORD_W-1:0]  ea_o
);
  localparam int PCOFF_W = 9;
  localparam int BOFF_W  = 6;

  logic [WORD_W-1:0] pc_off, base_off;

  assign pc_off   = {{(WORD_W-PCOFF_W){instr_i[PCOFF_W-1]}}, instr_i[PCOFF_W-1:0]};
  assign base_off = {{(WORD_W-BOFF_W){instr_i[BOFF_W-1]}}, instr_i[BOFF_W-1:0]};

  // one adder, operands muxed by mode
  always_comb begin
    if (op_base(instr_i[15:12])) ea_o = base_val_i + base_off;
    else                         ea_o = pc_next_i + pc_off;
  end
endmodule

// File: rtl/ldst_fsm.sv
module ldst_fsm
  import ldst_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [WORD_W-1:0]    pc_next_i,
  input  logic [WORD_W-1:0]    base_val_i,
  input  logic [WORD_W-1:0]    src_val_i,
  input  logic [WORD_W-1:0]    ea_i,
  output logic [INSTR_W-1:0]   instr_q_o,
  output logic [WORD_W-1:0]    pc_q_o,
  output logic [WORD_W-1:0]    base_q_o,
  input  logic                 mem_ready_i,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic [WORD_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 wr_en_o,
  output logic [REG_IDX_W-1:0] wr_idx_o,
  output logic [WORD_W-1:0]    wr_data_o
);
  state_e              state_q;
  logic [INSTR_W-1:0]  instr_q;
  logic [WORD_W-1:0]   pc_q, base_q, src_q, addr_q, data_q;
  logic [3:0]          op;

  assign op = instr_q[15:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      instr_q <= '0;
      pc_q    <= '0;
      base_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i && op_valid(instr_i[15:12])) begin
          instr_q <= instr_i;
          pc_q    <= pc_next_i;
          base_q  <= base_val_i;
          src_q   <= src_val_i;
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          addr_q <= ea_i;
          if (op == OP_LEA) begin
            data_q  <= ea_i;
            state_q <= ST_DONE;
          end else if (op_indirect(op)) state_q <= ST_RD1;
          else                          state_q <= ST_ACCESS;
        end
        ST_RD1: if (mem_ready_i) begin
          addr_q  <= mem_rdata_i;  // pointer becomes the final address
          state_q <= ST_ACCESS;
        end
        ST_ACCESS: if (mem_ready_i) begin
          if (!op_store(op)) data_q <= mem_rdata_i;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign instr_q_o   = instr_q;
  assign pc_q_o      = pc_q;
  assign base_q_o    = base_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = src_q;
  assign mem_rd_o    = (state_q == ST_RD1) || ((state_q == ST_ACCESS) && !op_store(op));
  assign mem_wr_o    = (state_q == ST_ACCESS) && op_store(op);
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign wr_en_o     = (state_q == ST_DONE) && !op_store(op);
  assign wr_idx_o    = instr_q[11:9];
  assign wr_data_o   = data_q;

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && !mem_ready_i) |=>
      ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_rd_o) && $stable(mem_wr_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  wr_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);

  // R10
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_rd_o || mem_wr_o || done_o));
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [15:0]          instr_i,
  input  logic [WORD_W-1:0]    pc_next_i,
  input  logic [WORD_W-1:0]    base_val_i,
  input  logic [WORD_W-1:0]    src_val_i,
  output logic                 busy_o,
  output logic [WORD_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  input  logic                 mem_ready_i,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic                 done_o,
  output logic                 wr_en_o,
  output logic [2:0]           wr_idx_o,
  output logic [WORD_W-1:0]    wr_data_o
);
  logic [INSTR_W-1:0] instr_q;
  logic [WORD_W-1:0]  pc_q, base_q, ea;

  ldst_ea #(.WORD_W(WORD_W)) u_ea (
    .instr_i    (instr_q),
    .pc_next_i  (pc_q),
    .base_val_i (base_q),
    .ea_o       (ea)
  );

  ldst_fsm #(.WORD_W(WORD_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .instr_i     (instr_i),
    .pc_next_i   (pc_next_i),
    .base_val_i  (base_val_i),
    .src_val_i   (src_val_i),
    .ea_i        (ea),
    .instr_q_o   (instr_q),
    .pc_q_o      (pc_q),
    .base_q_o    (base_q),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .wr_en_o     (wr_en_o),
    .wr_idx_o    (wr_idx_o),
    .wr_data_o   (wr_data_o)
  );
endmodule

// File: tb/ldst_seq_test.sv
module ldst_seq_test;
  localparam int CLK_P = 10;
  localparam int MEM_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc = '0, base = '0, src = '0;
  logic        busy, rd, wr, done, wr_en;
  logic [15:0] addr, wdata, rdata, wr_data;
  logic [2:0]  wr_idx;
  logic        ready = 1'b1;

  logic [15:0] mem     [MEM_N];
  logic [15:0] ref_mem [MEM_N];

  typedef struct {
    bit          is_wr;
    logic [15:0] a;
    logic [15:0] d;
  } acc_t;
  acc_t acc_q[$];

  int   total = 0, bad = 0;
  int   rdy_mode = 0, rdy_cnt = 0;
  int   acc_cnt = 0, exp_n = 0;
  bit   exp_active = 0, exp_we = 0, done_seen = 0, fin = 0;
  logic [2:0]  exp_idx = '0;
  logic [15:0] exp_res = '0;
  string cur_tag = "";

  always #(CLK_P/2) clk = ~clk;

  ldst_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .pc_next_i(pc), .base_val_i(base), .src_val_i(src), .busy_o(busy),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rd_o(rd), .mem_wr_o(wr),
    .mem_ready_i(ready), .mem_rdata_i(rdata), .done_o(done), .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  assign rdata = mem[addr[11:0]];

  always @(posedge clk) if (wr && ready) mem[addr[11:0]] <= wdata;

  always @(negedge clk) begin
    rdy_cnt++;
    ready <= (rdy_mode == 0) ? 1'b1 : (rdy_cnt % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the behavioural expectation
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      if (rd && wr) chk(0, "R7 both strobes", {rd, wr}, 0);
      if ((rd || wr) && ready) begin
        if (acc_q.size() == 0) chk(0, {cur_tag, " R5 unexpected transfer"}, addr, 0);
        else begin
          acc_t e;
          e = acc_q.pop_front();
          acc_cnt++;
          chk(wr == e.is_wr, {cur_tag, " R6 transfer kind"}, {15'd0, wr}, {15'd0, e.is_wr});
          chk(addr == e.a, {cur_tag, " address"}, addr, e.a);
          if (e.is_wr) chk(wdata == e.d, {cur_tag, " R6 write data"}, wdata, e.d);
        end
      end
      if (wr_en && !done) chk(0, "R9 write without done", 1, 0);
      if (done) begin
        if (!exp_active) chk(0, "R1 unexpected done", 1, 0);
        else begin
          chk(acc_cnt == exp_n, {cur_tag, " R5 transfer count"}, acc_cnt[15:0], exp_n[15:0]);
          chk(wr_en == exp_we, {cur_tag, " R9 write enable"}, {15'd0, wr_en}, {15'd0, exp_we});
          if (exp_we) begin
            chk(wr_idx == exp_idx, {cur_tag, " R9 index"}, {13'd0, wr_idx}, {13'd0, exp_idx});
            chk(wr_data == exp_res, {cur_tag, " R9 data"}, wr_data, exp_res);
          end
          exp_active = 0;
          done_seen = 1;
        end
      end
    end
  end

  task automatic run_op(input logic [15:0] ins, input logic [15:0] p, input logic [15:0] b,
                        input logic [15:0] s, input int exp_lat, input bit hold2, input string tag);
    logic [15:0] pcrel, boff, ptr;
    int lat;
    pcrel = p + {{7{ins[8]}}, ins[8:0]};
    boff  = b + {{10{ins[5]}}, ins[5:0]};
    acc_q.delete();
    acc_cnt = 0;
    exp_we = 0;
    exp_idx = ins[11:9];
    cur_tag = tag;
    case (ins[15:12])
      4'h2: begin acc_q.push_back('{0, pcrel, 0}); exp_we = 1; exp_res = ref_mem[pcrel[11:0]]; end
      4'h3: begin acc_q.push_back('{1, pcrel, s}); ref_mem[pcrel[11:0]] = s; end
      4'h6: begin acc_q.push_back('{0, boff, 0}); exp_we = 1; exp_res = ref_mem[boff[11:0]]; end
      4'h7: begin acc_q.push_back('{1, boff, s}); ref_mem[boff[11:0]] = s; end
      4'hA: begin
        ptr = ref_mem[pcrel[11:0]];
        acc_q.push_back('{0, pcrel, 0});
        acc_q.push_back('{0, ptr, 0});
        exp_we = 1; exp_res = ref_mem[ptr[11:0]];
      end
      4'hB: begin
        ptr = ref_mem[pcrel[11:0]];
        acc_q.push_back('{0, pcrel, 0});
        acc_q.push_back('{1, ptr, s});
        ref_mem[ptr[11:0]] = s;
      end
      default: begin exp_we = 1; exp_res = pcrel; end
    endcase
    exp_n = acc_q.size();
    done_seen = 0;
    exp_active = 1;
    @(negedge clk);
    instr = ins; pc = p; base = b; src = s; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      if (!hold2 || lat == 1) start = 1'b0;
      #(CLK_P/4 + 1);
      lat++;
    end while (!done_seen && lat < 200);
    if (exp_lat > 0) chk(lat == exp_lat, {tag, " R8 latency"}, lat[15:0], exp_lat[15:0]);
    @(negedge clk);
    #(CLK_P/4 + 1);
    chk(!busy, {tag, " R10 idle after done"}, {15'd0, busy}, 0);
    chk(acc_q.size() == 0, {tag, " R5 leftover transfers"}, acc_q.size(), 0);
  endtask

  task automatic bad_op(input logic [15:0] ins);
    cur_tag = "R1";
    @(negedge clk);
    instr = ins; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      #(CLK_P/4 + 1);
      chk(!busy && !done && !rd && !wr, "R1 ignored opcode", ins, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 16'd0, 16'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 16'(i * 7 + 16'h1111);
      ref_mem[i] = 16'(i * 7 + 16'h1111);
    end
    mem[12'h006] = 16'h0123; ref_mem[12'h006] = 16'h0123;  // pointer at 0x3006
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk(!busy && !done && !wr_en && !rd && !wr, "R11 reset state",
        {11'd0, busy, done, wr_en, rd, wr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    chk(!busy && !done && !wr_en && !rd && !wr, "R11 after release",
        {11'd0, busy, done, wr_en, rd, wr}, 0);

    rdy_mode = 0;
    run_op(16'h2605, 16'h3000, 16'h0, 16'h0, 3, 0, "R2 ld");
    run_op(16'hE3FD, 16'h30F7, 16'h0, 16'h0, 2, 0, "R2 lea back");
    run_op(16'h34FF, 16'h3000, 16'h0, 16'hBEEF, 3, 0, "R2 st +255");
    run_op(16'h28FF, 16'h3000, 16'h0, 16'h0, 3, 0, "R6 st readback");
    run_op(16'h2B00, 16'h3000, 16'h0, 16'h0, 3, 0, "R2 ld -256");
    run_op(16'hA205, 16'h3001, 16'h0, 16'h0, 4, 0, "R4 ldi");
    run_op(16'hB605, 16'h3001, 16'h0, 16'h5A5A, 4, 0, "R4 sti");
    run_op(16'h6C20, 16'h0, 16'h0010, 16'h0, 3, 0, "R3 ldr -32");
    run_op(16'h7E1F, 16'h0, 16'h0123, 16'h1357, 3, 0, "R3 str +31");
    run_op(16'hE001, 16'hFFFF, 16'h0, 16'h0, 2, 0, "R2 lea wrap");

    rdy_mode = 1;
    run_op(16'hA205, 16'h3001, 16'h0, 16'h0, 0, 0, "R4 ldi stalled");
    run_op(16'hB605, 16'h3001, 16'h0, 16'hC3C3, 0, 0, "R4 sti stalled");
    run_op(16'h6A20, 16'h0, 16'h0143, 16'h0, 0, 0, "R3 ldr stalled");
    run_op(16'h2605, 16'h3000, 16'h0, 16'h0, 0, 1, "R10 start held");
    run_op(16'hEDFF, 16'h1000, 16'h0, 16'h0, 0, 1, "R10 lea held");

    bad_op(16'h1234);
    bad_op(16'h903F);
    bad_op(16'h0E01);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule